// File: doc/BRIEF.md
# Chained Vector Add Unit

This block is a small vector execution engine. It holds a bank of vector registers and runs three-register add instructions that compute `dst = srca + srcb` element by element. An instruction is decoded once when it is accepted. After that, one element per cycle flows through a fixed-latency pipelined adder, with no further decode. The integer sum wraps modulo 2^W and produces no carry.

The block has two execution slots, so at most two instructions are in flight at once. If a younger instruction reads a register that the older one is still producing, the younger one chains onto it. It takes each element directly from the producer's adder output in the cycle that element emerges, instead of waiting for the whole register to be written back. A per-slot count of written elements tells the consumer which elements already sit in the register file. An instruction whose destination is read or written by an in-flight instruction is held off at the instruction port. A vector-length register bounds how many leading elements each instruction processes. A scalar port fills and reads back single elements while the unit is idle.

Top module: `vchain_add`

## Requirements
- R1: After reset, `busy` is 0, `instr_ready` is 1, `sc_rdata` is 0, and the vector length is NELEM (64).
- R2: For each element index i below the instruction's vector length, the destination element i becomes srca[i] + srcb[i] modulo 2^64, using the source values that program order implies.
- R3: Destination elements at index equal to or above the instruction's vector length keep their previous value.
- R4: A vector-length write with a value from 1 to NELEM takes effect for instructions accepted afterwards. A write of 0 or of a value above NELEM is ignored. Each instruction captures the length at acceptance.
- R5: An instruction accepted alone with vector length N keeps `busy` high for exactly N+3 cycles after the accepting edge. This follows from a 3-cycle adder latency.
- R6: Chaining: a consumer accepted one cycle after its producer, both with length N, issues element i in the cycle the producer's element i leaves the adder. `busy` stays high for N+6 cycles after the producer's accepting edge.
- R7: An instruction whose destination equals the destination or a source of an in-flight instruction is not accepted (`instr_ready` = 0) until that instruction completes.
- R8: While two instructions are in flight, `instr_ready` is 0.
- R9: A scalar write is applied only while `busy` is 0 and is ignored otherwise. A scalar read returns the element at {`sc_reg`,`sc_idx`} on `sc_rdata` one cycle after the address is presented.
- R10: An instruction whose destination is also one or both of its sources (for example v4 = v4 + v4) reads each element's old value before overwriting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An add instruction is presented |
| instr_ready | output | 1 | The instruction is accepted at this edge if valid |
| instr_dst | input | 3 | Destination register number |
| instr_srca | input | 3 | First source register number |
| instr_srcb | input | 3 | Second source register number |
| vl_we | input | 1 | Write the vector-length register |
| vl_wdata | input | 7 | New vector length (1..64 accepted) |
| sc_we | input | 1 | Scalar element write strobe |
| sc_reg | input | 3 | Scalar access register number |
| sc_idx | input | 6 | Scalar access element index |
| sc_wdata | input | 64 | Scalar write data |
| sc_rdata | output | 64 | Registered scalar read data |
| busy | output | 1 | At least one instruction is in flight |

## Verification
The assertions check the following on every cycle:
- Each slot's adder output carries the element index equal to that slot's written count, and never an index at or past its captured length.
- A chained consumer never issues an element its producer has not yet emitted.
- No instruction is accepted while both slots are occupied or while its destination collides with an in-flight register.
- The length register stays within 1..64.

Only the bench's scenarios can show:
- The arithmetic results and wraparound.
- That elements beyond the length are preserved.
- The exact busy durations that prove the 3-cycle latency and the overlap gained by chaining.
- That scalar writes issued while busy leave the register file untouched.

// File: rtl/vadd_pkg.sv
package vadd_pkg;
    localparam int unsigned DEF_NREG  = 8;
    localparam int unsigned DEF_NELEM = 64;
    localparam int unsigned DEF_W     = 64;
    localparam int unsigned DEF_LAT   = 3;
    localparam int unsigned NUM_SLOTS = 2;
    localparam int unsigned NUM_RD    = 2 * NUM_SLOTS;
endpackage

// File: rtl/vadd_regfile.sv
module vadd_regfile #(
    parameter int unsigned NREG  = 8,
    parameter int unsigned NELEM = 64,
    parameter int unsigned W     = 64,
    parameter int unsigned NWR   = 2,
    parameter int unsigned NRD   = 4,
    localparam int unsigned AW   = $clog2(NREG) + $clog2(NELEM)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NWR-1:0]           wr_en,
    input  logic [NWR-1:0][AW-1:0]   wr_addr,
    input  logic [NWR-1:0][W-1:0]    wr_data,
    input  logic                     sc_we,
    input  logic [AW-1:0]            sc_addr,
    input  logic [W-1:0]             sc_wdata,
    input  logic [NRD-1:0][AW-1:0]   rd_addr,
    output logic [NRD-1:0][W-1:0]    rd_data,
    output logic [W-1:0]             sc_rdata
);
    localparam int unsigned DEPTH = NREG * NELEM;

    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] scr_d, scr_q;

    // storage array: element writes from the adders plus the scalar port
    always_ff @(posedge clk) begin
        for (int p = 0; p < int'(NWR); p++) begin
            if (wr_en[p]) mem[wr_addr[p]] <= wr_data[p];
        end
        if (sc_we) mem[sc_addr] <= sc_wdata;
    end

    always_comb begin
        for (int p = 0; p < int'(NRD); p++) rd_data[p] = mem[rd_addr[p]];
        scr_d = mem[sc_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) scr_q <= '0;
        else        scr_q <= scr_d;
    end

    assign sc_rdata = scr_q;
endmodule

// File: rtl/vadd_addpipe.sv
module vadd_addpipe #(
    parameter int unsigned W   = 64,
    parameter int unsigned IW  = 6,
    parameter int unsigned LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [IW-1:0] in_idx,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    output logic          out_valid,
    output logic [IW-1:0] out_idx,
    output logic [W-1:0]  out_data
);
    typedef struct packed {
        logic          valid;
        logic [IW-1:0] idx;
        logic [W-1:0]  sum;
    } stage_t;

    stage_t stg_d [LAT];
    stage_t stg_q [LAT];

    always_comb begin
        stg_d[0].valid = in_valid;
        stg_d[0].idx   = in_idx;
        stg_d[0].sum   = in_a + in_b;   // wraps, carry dropped
        for (int k = 1; k < int'(LAT); k++) stg_d[k] = stg_q[k-1];
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < int'(LAT); k++) begin
            if (!rst_n) stg_q[k] <= '0;
            else        stg_q[k] <= stg_d[k];
        end
    end

    assign out_valid = stg_q[LAT-1].valid;
    assign out_idx   = stg_q[LAT-1].idx;
    assign out_data  = stg_q[LAT-1].sum;
endmodule

// File: rtl/vadd_slot.sv
module vadd_slot #(
    parameter int unsigned RW = 3,
    parameter int unsigned LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] st_dst,
    input  logic [RW-1:0] st_srca,
    input  logic [RW-1:0] st_srcb,
    input  logic [LW-1:0] st_vl,
    input  logic          go,
    input  logic          wr_fire,
    output logic          active,
    output logic [RW-1:0] dst,
    output logic [RW-1:0] srca,
    output logic [RW-1:0] srcb,
    output logic [LW-1:0] vl,
    output logic [LW-1:0] icnt,
    output logic [LW-1:0] wcnt,
    output logic          issue_pend
);
    typedef struct packed {
        logic          active;
        logic [RW-1:0] dst;
        logic [RW-1:0] srca;
        logic [RW-1:0] srcb;
        logic [LW-1:0] vl;
        logic [LW-1:0] icnt;
        logic [LW-1:0] wcnt;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.active = 1'b1;
            s_d.dst    = st_dst;
            s_d.srca   = st_srca;
            s_d.srcb   = st_srcb;
            s_d.vl     = st_vl;
            s_d.icnt   = '0;
            s_d.wcnt   = '0;
        end else if (s_q.active) begin
            if (go)      s_d.icnt = s_q.icnt + 1'b1;
            if (wr_fire) s_d.wcnt = s_q.wcnt + 1'b1;
            if (s_d.wcnt == s_q.vl) s_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active     = s_q.active;
    assign dst        = s_q.dst;
    assign srca       = s_q.srca;
    assign srcb       = s_q.srcb;
    assign vl         = s_q.vl;
    assign icnt       = s_q.icnt;
    assign wcnt       = s_q.wcnt;
    assign issue_pend = s_q.active && (s_q.icnt < s_q.vl);
endmodule

// File: rtl/vchain_add.sv
module vchain_add #(
    parameter int unsigned NREG  = vadd_pkg::DEF_NREG,
    parameter int unsigned NELEM = vadd_pkg::DEF_NELEM,
    parameter int unsigned W     = vadd_pkg::DEF_W,
    parameter int unsigned LAT   = vadd_pkg::DEF_LAT,
    localparam int unsigned RW   = $clog2(NREG),
    localparam int unsigned IW   = $clog2(NELEM),
    localparam int unsigned LW   = $clog2(NELEM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    output logic          instr_ready,
    input  logic [RW-1:0] instr_dst,
    input  logic [RW-1:0] instr_srca,
    input  logic [RW-1:0] instr_srcb,
    input  logic          vl_we,
    input  logic [LW-1:0] vl_wdata,
    input  logic          sc_we,
    input  logic [RW-1:0] sc_reg,
    input  logic [IW-1:0] sc_idx,
    input  logic [W-1:0]  sc_wdata,
    output logic [W-1:0]  sc_rdata,
    output logic          busy
);
    import vadd_pkg::*;

    localparam int unsigned AW = RW + IW;
    localparam int unsigned NS = NUM_SLOTS;

    typedef struct packed {
        logic [LW-1:0] vl;
    } top_t;

    top_t st_d, st_q;

    logic [NS-1:0]              slot_act, slot_go, slot_pend, slot_start, slot_haz;
    logic [NS-1:0][RW-1:0]      slot_dst, slot_srca, slot_srcb;
    logic [NS-1:0][LW-1:0]      slot_vl, slot_icnt, slot_wcnt;
    logic [NS-1:0]              pout_v;
    logic [NS-1:0][IW-1:0]      pout_idx;
    logic [NS-1:0][W-1:0]       pout_data;
    logic [NUM_RD-1:0][AW-1:0]  rd_addr;
    logic [NUM_RD-1:0][W-1:0]   rd_data;
    logic [NS-1:0][AW-1:0]      wr_addr;
    logic                       accept;
    logic                       rf_sc_we;

    // vector-length register
    always_comb begin
        st_d = st_q;
        if (vl_we && (vl_wdata != '0) && (vl_wdata <= LW'(NELEM))) st_d.vl = vl_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{vl: LW'(NELEM)};
        else        st_q <= st_d;
    end

    // issue control: destination must not touch any register an in-flight op uses
    always_comb begin
        for (int s = 0; s < int'(NS); s++) begin
            slot_haz[s] = slot_act[s] && ((instr_dst == slot_dst[s]) ||
                                          (instr_dst == slot_srca[s]) ||
                                          (instr_dst == slot_srcb[s]));
        end
        instr_ready   = !(&slot_act) && !(|slot_haz);
        accept        = instr_valid && instr_ready;
        slot_start[0] = accept && !slot_act[0];
        slot_start[1] = accept && slot_act[0];
    end

    assign busy     = |slot_act;
    assign rf_sc_we = sc_we && !busy;

    for (genvar s = 0; s < int'(NS); s++) begin : g_slot
        localparam int unsigned O = NS - 1 - s;

        logic          dep_a, dep_b, have_a, have_b, done_o;
        logic          byp_hit;
        logic [W-1:0]  opa, opb;

        vadd_slot #(.RW(RW), .LW(LW)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (slot_start[s]),
            .st_dst     (instr_dst),
            .st_srca    (instr_srca),
            .st_srcb    (instr_srcb),
            .st_vl      (st_q.vl),
            .go         (slot_go[s]),
            .wr_fire    (pout_v[s]),
            .active     (slot_act[s]),
            .dst        (slot_dst[s]),
            .srca       (slot_srca[s]),
            .srcb       (slot_srcb[s]),
            .vl         (slot_vl[s]),
            .icnt       (slot_icnt[s]),
            .wcnt       (slot_wcnt[s]),
            .issue_pend (slot_pend[s])
        );

        // operand availability and forwarding from the other slot's adder
        always_comb begin
            done_o  = slot_wcnt[O] > slot_icnt[s];
            byp_hit = pout_v[O] && (LW'(pout_idx[O]) == slot_icnt[s]);
            dep_a   = slot_act[O] && (slot_dst[O] == slot_srca[s]);
            dep_b   = slot_act[O] && (slot_dst[O] == slot_srcb[s]);
            have_a  = !dep_a || done_o || byp_hit;
            have_b  = !dep_b || done_o || byp_hit;
            opa     = (dep_a && !done_o) ? pout_data[O] : rd_data[2*s];
            opb     = (dep_b && !done_o) ? pout_data[O] : rd_data[2*s+1];
        end

        assign slot_go[s]     = slot_pend[s] && have_a && have_b;
        assign rd_addr[2*s]   = {slot_srca[s], slot_icnt[s][IW-1:0]};
        assign rd_addr[2*s+1] = {slot_srcb[s], slot_icnt[s][IW-1:0]};
        assign wr_addr[s]     = {slot_dst[s], pout_idx[s]};

        vadd_addpipe #(.W(W), .IW(IW), .LAT(LAT)) u_pipe (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (slot_go[s]),
            .in_idx    (slot_icnt[s][IW-1:0]),
            .in_a      (opa),
            .in_b      (opb),
            .out_valid (pout_v[s]),
            .out_idx   (pout_idx[s]),
            .out_data  (pout_data[s])
        );
    end

    vadd_regfile #(
        .NREG(NREG), .NELEM(NELEM), .W(W), .NWR(NS), .NRD(NUM_RD)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pout_v),
        .wr_addr  (wr_addr),
        .wr_data  (pout_data),
        .sc_we    (rf_sc_we),
        .sc_addr  ({sc_reg, sc_idx}),
        .sc_wdata (sc_wdata),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sc_rdata (sc_rdata)
    );
endmodule

// File: rtl/vadd_chk.sv
module vadd_chk #(
    parameter int unsigned RW    = 3,
    parameter int unsigned IW    = 6,
    parameter int unsigned LW    = 7,
    parameter int unsigned NELEM = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 instr_valid,
    input logic                 instr_ready,
    input logic [RW-1:0]        instr_dst,
    input logic                 busy,
    input logic [LW-1:0]        vl_q,
    input logic [1:0]           act,
    input logic [1:0]           go,
    input logic [1:0][RW-1:0]   dst,
    input logic [1:0][RW-1:0]   srca,
    input logic [1:0][RW-1:0]   srcb,
    input logic [1:0][LW-1:0]   vl,
    input logic [1:0][LW-1:0]   icnt,
    input logic [1:0][LW-1:0]   wcnt,
    input logic [1:0]           pv,
    input logic [1:0][IW-1:0]   pidx
);
    p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> instr_ready);

    p_wr_order0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pv[0] |-> (LW'(pidx[0]) == wcnt[0]));
    p_wr_order1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pv[1] |-> (LW'(pidx[1]) == wcnt[1]));

    p_in_len0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pv[0] |-> (LW'(pidx[0]) < vl[0]));
    p_in_len1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pv[1] |-> (LW'(pidx[1]) < vl[1]));

    p_vl_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_q != '0) && (vl_q <= LW'(NELEM)));

    p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready) |=> busy);

    p_chain_a0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go[0] && act[1] && dst[1] == srca[0]) |-> (icnt[0] <= wcnt[1]));
    p_chain_b0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go[0] && act[1] && dst[1] == srcb[0]) |-> (icnt[0] <= wcnt[1]));
    p_chain_a1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go[1] && act[0] && dst[0] == srca[1]) |-> (icnt[1] <= wcnt[0]));
    p_chain_b1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go[1] && act[0] && dst[0] == srcb[1]) |-> (icnt[1] <= wcnt[0]));

    p_war0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && act[0]) |->
        (instr_dst != dst[0] && instr_dst != srca[0] && instr_dst != srcb[0]));
    p_war1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && act[1]) |->
        (instr_dst != dst[1] && instr_dst != srca[1] && instr_dst != srcb[1]));

    p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&act) |-> !instr_ready);
endmodule

bind vchain_add vadd_chk #(.RW(RW), .IW(IW), .LW(LW), .NELEM(NELEM)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .instr_dst   (instr_dst),
    .busy        (busy),
    .vl_q        (st_q.vl),
    .act         (slot_act),
    .go          (slot_go),
    .dst         (slot_dst),
    .srca        (slot_srca),
    .srcb        (slot_srcb),
    .vl          (slot_vl),
    .icnt        (slot_icnt),
    .wcnt        (slot_wcnt),
    .pv          (pout_v),
    .pidx        (pout_idx)
);

// File: tb/test_vchain_add.sv
`timescale 1ns/1ps
module test_vchain_add;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [2:0]  instr_dst = '0, instr_srca = '0, instr_srcb = '0;
    logic        vl_we = 1'b0;
    logic [6:0]  vl_wdata = '0;
    logic        sc_we = 1'b0;
    logic [2:0]  sc_reg = '0;
    logic [5:0]  sc_idx = '0;
    logic [63:0] sc_wdata = '0;
    logic [63:0] sc_rdata;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    int cur_vl = 64;
    int cycles = 0;
    logic [63:0] mdl [8][64];

    always #5 clk = ~clk;

    vchain_add i_vchain_add (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_dst(instr_dst), .instr_srca(instr_srca), .instr_srcb(instr_srcb),
        .vl_we(vl_we), .vl_wdata(vl_wdata),
        .sc_we(sc_we), .sc_reg(sc_reg), .sc_idx(sc_idx),
        .sc_wdata(sc_wdata), .sc_rdata(sc_rdata), .busy(busy)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog (R5) actual=%0d expected<=150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [63:0] exp_sum(logic [63:0] a, logic [63:0] b);
        return a + b;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sc_write(input int r, input int i, input logic [63:0] d, input bit upd);
        sc_we = 1'b1; sc_reg = 3'(r); sc_idx = 6'(i); sc_wdata = d;
        @(negedge clk);
        sc_we = 1'b0;
        if (upd) mdl[r][i] = d;
    endtask

    task automatic sc_read(input int r, input int i, output logic [63:0] d);
        sc_reg = 3'(r); sc_idx = 6'(i);
        @(negedge clk);
        d = sc_rdata;
    endtask

    task automatic set_vl(input int v);
        vl_we = 1'b1; vl_wdata = 7'(v);
        @(negedge clk);
        vl_we = 1'b0;
        if (v >= 1 && v <= 64) cur_vl = v;
    endtask

    task automatic issue(input int d, input int a, input int b, output int waits);
        instr_valid = 1'b1; instr_dst = 3'(d); instr_srca = 3'(a); instr_srcb = 3'(b);
        waits = 0;
        #1;
        while (!instr_ready) begin waits++; @(negedge clk); end
        @(negedge clk);
        instr_valid = 1'b0;
        for (int i = 0; i < cur_vl; i++) mdl[d][i] = exp_sum(mdl[a][i], mdl[b][i]);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic check_reg(input int r, input string req);
        logic [63:0] got;
        int bad = -1;
        logic [63:0] bad_got, bad_exp;
        for (int i = 0; i < 64; i++) begin
            sc_read(r, i, got);
            if (got !== mdl[r][i] && bad < 0) begin
                bad = i; bad_got = got; bad_exp = mdl[r][i];
            end
        end
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s reg %0d idx %0d actual=%h expected=%h", req, r, bad, bad_got, bad_exp);
        end
    endtask

    initial begin
        int w, cnt;
        logic [63:0] v;
        void'($urandom(32'h1c0ffee));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 ready", 64'(instr_ready), 64'd1);
        chk("R1 sc_rdata", sc_rdata, 64'd0);
        @(negedge clk);

        // fill every register with random data; R9 write path
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 64; i++) sc_write(r, i, {$urandom, $urandom}, 1'b1);
        sc_write(0, 0, 64'hffff_ffff_ffff_ffff, 1'b1);
        sc_write(1, 0, 64'h0000_0000_0000_0002, 1'b1);
        check_reg(0, "R9 scalar readback");

        // R1/R2: default length covers all 64 elements, wraparound at element 0
        issue(2, 0, 1, w);
        wait_idle();
        check_reg(2, "R1 R2 full-length add with wrap");
        sc_read(2, 0, v);
        chk("R2 wrap modulo 2^64", v, 64'd1);

        // R4: illegal lengths ignored; R5: isolated latency; R3: tail kept
        set_vl(5);
        set_vl(0);
        set_vl(70);
        issue(3, 4, 5, w);
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        chk("R5 R4 busy length for vl=5", 64'(cnt), 64'd8);
        check_reg(3, "R3 R4 elements beyond length kept");

        // R6: chained consumer follows producer immediately
        set_vl(10);
        issue(6, 0, 1, w);
        issue(7, 6, 6, w);
        chk("R6 consumer accepted without wait", 64'(w), 64'd0);
        cnt = 1;
        while (busy) begin cnt++; @(negedge clk); end
        chk("R6 chained busy length", 64'(cnt), 64'd16);
        check_reg(6, "R6 producer result");
        check_reg(7, "R6 chained result");

        // R10: destination equals sources
        set_vl(64);
        issue(4, 4, 4, w);
        wait_idle();
        check_reg(4, "R10 self-referencing add");

        // R7: write-after-read stall
        issue(1, 2, 3, w);
        issue(2, 4, 5, w);
        chk("R7 stalled on WAR", 64'(w > 0), 64'd1);
        wait_idle();
        check_reg(1, "R7 reader saw old source");
        check_reg(2, "R7 writer result");

        // R8: two in flight blocks a third
        issue(0, 1, 2, w);
        issue(3, 4, 5, w);
        issue(6, 7, 7, w);
        chk("R8 third instruction stalled", 64'(w > 0), 64'd1);
        wait_idle();
        check_reg(0, "R8 first"); check_reg(3, "R8 second"); check_reg(6, "R8 third");

        // R9: scalar write while busy is ignored
        issue(5, 6, 7, w);
        sc_write(0, 3, 64'hdead_beef_0000_0001, 1'b0);
        wait_idle();
        sc_read(0, 3, v);
        chk("R9 scalar write ignored while busy", v, mdl[0][3]);

        // random rounds mixing lengths, hazards and chains
        for (int rnd = 0; rnd < 14; rnd++) begin
            int n = 1 + int'($urandom_range(2));
            for (int k = 0; k < n; k++) begin
                if ($urandom_range(2) == 0) set_vl(1 + int'($urandom_range(63)));
                issue(int'($urandom_range(7)), int'($urandom_range(7)),
                      int'($urandom_range(7)), w);
            end
            wait_idle();
            for (int r = 0; r < 8; r++) check_reg(r, "R2 R3 R6 random round");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule